// File: doc/BRIEF.md
# NMI Event Controller with Reset Countdown

This block collects seven non-maskable event sources into one 32-bit control word. It drives a single NMI line from that word. The sources are a deadman timeout, a watchdog timeout while running, a watchdog timeout while asleep, an external event, a low-voltage event, a clock failure and a software trigger. Each hardware source sets a sticky flag. Software can set any flag to fake its event, and it clears a flag by writing zero to it. All writes take effect only while the unlock input is high.

Two of the sources also start a reset countdown: the deadman flag and the run-mode watchdog flag. The countdown is loaded from a programmable reload field. If software has not cleared both of those flags by the time the count runs out, the block issues a one-cycle device reset pulse. The sleep-mode watchdog flag also raises a wake request. The event detectors and the unlock sequence are outside the block.

Top module: `nmi_ctrl`

## Requirements
- R1: A write with `unlock_i` low changes no field. The register image stays as it was, apart from flags set by hardware events.
- R2: After reset every field reads zero. The read layout is: deadman flag at bit 25, run watchdog flag at bit 24, software trigger at bit 23, external at bit 19, low voltage at bit 18, clock fail at bit 17, sleep watchdog at bit 16, and the reload value at bits 15:0. All other bits read zero.
- R3: A hardware event input that is high at a clock edge sets its flag from the next cycle. The flag stays set until software writes 0 to it. If an event and a clearing write happen in the same cycle, the event wins.
- R4: An unlocked write loads every flag from the written bit. Writing 1 sets the flag, with the same NMI effect as the real event, and writing 0 clears it.
- R5: Writing 1 to bit 23 gives an NMI and a read value of 1 for exactly the next cycle. Writing 0 to bit 23 has no effect.
- R6: `nmi_o` is high exactly when any flag or the software trigger reads as 1.
- R7: The deadman or run watchdog flag can change from clear to set while the reload field holds R > 0. If the flag stays set, `dev_rst_o` is high for one cycle, R+1 cycles after the first cycle the flag reads set.
- R8: With a reload of zero, `dev_rst_o` is high in the cycle right after the arming flag first reads set.
- R9: If both arming flags are cleared before the countdown ends, no reset is issued. A later arming starts a fresh count.
- R10: The external, low-voltage, clock-fail, sleep watchdog and software-trigger sources never cause `dev_rst_o`.
- R11: `wake_o` is high exactly while the sleep watchdog flag is set.
- R12: The reload value is captured when the countdown starts, so a write to the reload field during a count does not change when the reset fires. While an arming flag stays set after its reset, no second reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock_i | input | 1 | Write enable gate from the unlock logic |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register image |
| ev_dmt_i | input | 1 | Deadman timeout event |
| ev_wdt_run_i | input | 1 | Watchdog timeout in run mode |
| ev_wdt_slp_i | input | 1 | Watchdog timeout in sleep |
| ev_ext_i | input | 1 | External NMI event |
| ev_lvd_i | input | 1 | Low-voltage event |
| ev_clkf_i | input | 1 | Clock failure event |
| nmi_o | output | 1 | Non-maskable interrupt |
| wake_o | output | 1 | Wake-from-sleep request |
| dev_rst_o | output | 1 | One-cycle device reset request |

## Verification
The assertions assume that the event inputs and the write strobe are synchronous to `clk` and that each is sampled once per edge. They also assume that the countdown sees only the two arming flags. The stimulus keeps event pulses sparse and writes to one in eight cycles. It masks the reload value to at most 15 during random runs, so full countdowns finish and race against clearing writes within the run. Directed sequences cover a reload of zero, a clear just in time and a reload change during a count.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    localparam int REG_W   = 32;
    localparam int BIT_DMT = 25;
    localparam int BIT_WDR = 24;
    localparam int BIT_SWT = 23;
    localparam int BIT_EXT = 19;
    localparam int BIT_LVD = 18;
    localparam int BIT_CLK = 17;
    localparam int BIT_WDS = 16;

    typedef struct packed {
        logic dmt;
        logic wdr;
        logic ext;
        logic lvd;
        logic clkf;
        logic wds;
    } nmi_flags_t;

    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_COUNT = 2'd1,
        T_DONE  = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/nmi_flag_reg.sv
module nmi_flag_reg
    import nmi_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ok_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  nmi_flags_t          ev_i,
    output nmi_flags_t          flags_o,
    output logic                swt_o,
    output logic [CNT_W-1:0]    reload_o
);
    typedef struct packed {
        nmi_flags_t       flags;
        logic             swt;
        logic [CNT_W-1:0] reload;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.swt = 1'b0;
        if (wr_ok_i) begin
            st_d.flags.dmt  = wr_data_i[BIT_DMT];
            st_d.flags.wdr  = wr_data_i[BIT_WDR];
            st_d.flags.ext  = wr_data_i[BIT_EXT];
            st_d.flags.lvd  = wr_data_i[BIT_LVD];
            st_d.flags.clkf = wr_data_i[BIT_CLK];
            st_d.flags.wds  = wr_data_i[BIT_WDS];
            st_d.swt        = wr_data_i[BIT_SWT];
            st_d.reload     = wr_data_i[CNT_W-1:0];
        end
        st_d.flags = st_d.flags | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o  = st_q.flags;
    assign swt_o    = st_q.swt;
    assign reload_o = st_q.reload;

    assert_locked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok_i && ev_i == '0) |=> ($stable(st_q.flags) && $stable(st_q.reload)));

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((st_q.flags & $past(ev_i)) == $past(ev_i)));

    assert_swt_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok_i) |=> !st_q.swt);
endmodule

// File: rtl/nmi_rst_timer.sv
module nmi_rst_timer
    import nmi_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             rst_o
);
    typedef struct packed {
        tmr_state_t       st;
        logic [CNT_W-1:0] cnt;
        logic             rst;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.rst = 1'b0;
        unique case (t_q.st)
            T_IDLE: begin
                if (arm_i) begin
                    if (reload_i == '0) begin
                        t_d.rst = 1'b1;
                        t_d.st  = T_DONE;
                    end else begin
                        t_d.cnt = reload_i - 1'b1;
                        t_d.st  = T_COUNT;
                    end
                end
            end
            T_COUNT: begin
                if (!arm_i) begin
                    t_d.st = T_IDLE;
                end else if (t_q.cnt == '0) begin
                    t_d.rst = 1'b1;
                    t_d.st  = T_DONE;
                end else begin
                    t_d.cnt = t_q.cnt - 1'b1;
                end
            end
            T_DONE: begin
                if (!arm_i) t_d.st = T_IDLE;
            end
            default: t_d.st = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rst_o = t_q.rst;

    assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.rst |=> !t_q.rst);

    assert_rst_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.rst) |-> $past(arm_i));

    assert_clear_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == T_COUNT && !arm_i) |=> !t_q.rst);

    assert_done_no_repeat_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == T_DONE && arm_i) |=> !t_q.rst);
endmodule

// File: rtl/nmi_ctrl.sv
module nmi_ctrl
    import nmi_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlock_i,
    input  logic             wr_en_i,
    input  logic [31:0]      wr_data_i,
    output logic [31:0]      rd_data_o,
    input  logic             ev_dmt_i,
    input  logic             ev_wdt_run_i,
    input  logic             ev_wdt_slp_i,
    input  logic             ev_ext_i,
    input  logic             ev_lvd_i,
    input  logic             ev_clkf_i,
    output logic             nmi_o,
    output logic             wake_o,
    output logic             dev_rst_o
);
    nmi_flags_t       ev, flags;
    logic             swt;
    logic [CNT_W-1:0] reload;
    logic             wr_ok;
    logic             arm;

    assign wr_ok = wr_en_i & unlock_i;

    always_comb begin
        ev.dmt  = ev_dmt_i;
        ev.wdr  = ev_wdt_run_i;
        ev.ext  = ev_ext_i;
        ev.lvd  = ev_lvd_i;
        ev.clkf = ev_clkf_i;
        ev.wds  = ev_wdt_slp_i;
    end

    nmi_flag_reg #(.CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok_i   (wr_ok),
        .wr_data_i (wr_data_i),
        .ev_i      (ev),
        .flags_o   (flags),
        .swt_o     (swt),
        .reload_o  (reload)
    );

    assign arm = flags.dmt | flags.wdr;

    nmi_rst_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .reload_i (reload),
        .rst_o    (dev_rst_o)
    );

    always_comb begin
        rd_data_o              = '0;
        rd_data_o[BIT_DMT]     = flags.dmt;
        rd_data_o[BIT_WDR]     = flags.wdr;
        rd_data_o[BIT_SWT]     = swt;
        rd_data_o[BIT_EXT]     = flags.ext;
        rd_data_o[BIT_LVD]     = flags.lvd;
        rd_data_o[BIT_CLK]     = flags.clkf;
        rd_data_o[BIT_WDS]     = flags.wds;
        rd_data_o[CNT_W-1:0]   = reload;
    end

    assign nmi_o  = (flags != '0) | swt;
    assign wake_o = flags.wds;

    assert_event_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_dmt_i | ev_wdt_run_i | ev_wdt_slp_i | ev_ext_i | ev_lvd_i | ev_clkf_i) |=> nmi_o);

    assert_sleep_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_slp_i |=> wake_o);

    assert_sw_set_nmi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && (wr_data_i[BIT_DMT] | wr_data_i[BIT_SWT] | wr_data_i[BIT_EXT])) |=> nmi_o);
endmodule

// File: tb/nmi_ctrl_tb.sv
module nmi_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unlock_i = 1'b0, wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        ev_dmt_i = 0, ev_wdt_run_i = 0, ev_wdt_slp_i = 0;
    logic        ev_ext_i = 0, ev_lvd_i = 0, ev_clkf_i = 0;
    logic        nmi_o, wake_o, dev_rst_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nmi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .ev_dmt_i(ev_dmt_i), .ev_wdt_run_i(ev_wdt_run_i), .ev_wdt_slp_i(ev_wdt_slp_i),
        .ev_ext_i(ev_ext_i), .ev_lvd_i(ev_lvd_i), .ev_clkf_i(ev_clkf_i),
        .nmi_o(nmi_o), .wake_o(wake_o), .dev_rst_o(dev_rst_o)
    );

    // reference model; flag order {dmt,wdr,ext,lvd,clkf,wds}
    logic [5:0]  m_f = '0;
    logic        m_swt = 0;
    logic [15:0] m_rel = '0;
    int          m_st = 0;
    logic [15:0] m_cnt = '0;
    logic        m_rst = 0;

    function automatic logic [31:0] exp_rd();
        return {6'b0, m_f[5], m_f[4], m_swt, 3'b0, m_f[3], m_f[2], m_f[1], m_f[0], m_rel};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic [5:0] ev, input logic wo, input logic [31:0] d);
        logic [5:0]  nf = m_f;
        logic        nswt = 0;
        logic [15:0] nrel = m_rel;
        int          nst = m_st;
        logic [15:0] ncnt = m_cnt;
        logic        nrst = 0;
        logic        arm = m_f[5] | m_f[4];
        if (wo) begin
            nf = {d[25], d[24], d[19], d[18], d[17], d[16]};
            nswt = d[23];
            nrel = d[15:0];
        end
        nf = nf | ev;
        case (m_st)
            0: if (arm) begin
                   if (m_rel == 0) begin nrst = 1; nst = 2; end
                   else begin ncnt = m_rel - 1; nst = 1; end
               end
            1: if (!arm) nst = 0;
               else if (m_cnt == 0) begin nrst = 1; nst = 2; end
               else ncnt = m_cnt - 1;
            default: if (!arm) nst = 0;
        endcase
        m_f = nf; m_swt = nswt; m_rel = nrel; m_st = nst; m_cnt = ncnt; m_rst = nrst;
    endtask

    // one cycle: drive after a negedge, observe at the next negedge
    task automatic cyc(input logic [5:0] ev, input logic we, input logic ul, input logic [31:0] d);
        {ev_dmt_i, ev_wdt_run_i, ev_ext_i, ev_lvd_i, ev_clkf_i, ev_wdt_slp_i} = ev;
        wr_en_i = we; unlock_i = ul; wr_data_i = d;
        @(negedge clk);
        model_step(ev, we & ul, d);
        chk("R2 register image", rd_data_o, exp_rd());
        chk("R6 nmi", {31'b0, nmi_o}, {31'b0, (m_f != 0) | m_swt});
        chk("R11 wake", {31'b0, wake_o}, {31'b0, m_f[0]});
        chk("R7 reset", {31'b0, dev_rst_o}, {31'b0, m_rst});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(6'b0, 0, 0, 32'h0);
    endtask

    task automatic wr(input logic [31:0] d);
        cyc(6'b0, 1, 1, d);
    endtask

    // cycles until reset observed, up to lim; 0 if none
    task automatic wait_rst(input int lim, output int n);
        n = 0;
        for (int i = 1; i <= lim; i++) begin
            cyc(6'b0, 0, 0, 32'h0);
            if (dev_rst_o && n == 0) n = i;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk);
        chk("R2 reset image", rd_data_o, 32'h0);
        chk("R2 reset outputs", {29'b0, nmi_o, wake_o, dev_rst_o}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R1: locked write ignored
        cyc(6'b0, 1, 0, 32'h03FF_FFFF);
        chk("R1 locked write", rd_data_o, 32'h0);

        // R7: deadman, reload 5
        wr(32'h0000_0005);
        cyc(6'b100000, 0, 0, 0);
        wait_rst(10, n);
        chk("R7 reset delay", n, 6);
        // R12: flag still set, no second reset
        wait_rst(20, n);
        chk("R12 no repeat", n, 0);
        chk("R3 flag sticky", rd_data_o[25], 1'b1);

        // R8 and R4: software sets run watchdog with reload 0
        wr(32'h0000_0000);
        wr(32'h0100_0000);
        chk("R4 sw set flag", {31'b0, nmi_o}, 32'h1);
        wait_rst(5, n);
        chk("R8 zero reload", n, 1);

        // R9: clear in time
        wr(32'h0000_000A);
        cyc(6'b010000, 0, 0, 0);
        idle(4);
        wr(32'h0000_000A);
        wait_rst(20, n);
        chk("R9 cleared no reset", n, 0);
        // R3: event wins over clearing write
        cyc(6'b001000, 1, 1, 32'h0000_000A);
        chk("R3 event beats clear", rd_data_o[19], 1'b1);

        // R10 and R11: other sources, reload 0
        wr(32'h0000_0000);
        cyc(6'b001111, 0, 0, 0);
        chk("R11 wake on sleep wdt", {31'b0, wake_o}, 32'h1);
        wait_rst(10, n);
        chk("R10 no reset from others", n, 0);
        wr(32'h0000_0000);
        chk("R4 write zero clears", {31'b0, nmi_o}, 32'h0);

        // R5: software trigger pulse
        wr(32'h0080_0000);
        chk("R5 trigger nmi", {31'b0, nmi_o}, 32'h1);
        idle(1);
        chk("R5 trigger one cycle", {31'b0, nmi_o}, 32'h0);
        wr(32'h0000_0000);
        chk("R5 write zero no effect", {31'b0, nmi_o}, 32'h0);
        wait_rst(5, n);
        chk("R10 trigger no reset", n, 0);

        // R12: reload change during count
        wr(32'h0000_0008);
        cyc(6'b100000, 0, 0, 0);
        idle(2);
        wr(32'h0200_0002);
        wait_rst(15, n);
        chk("R12 captured reload", n, 6);
        wr(32'h0000_0000);

        // random phase
        for (int i = 0; i < 1500; i++) begin
            logic [5:0]  ev;
            logic        we, ul;
            logic [31:0] d;
            ev = '0;
            for (int b = 0; b < 6; b++) ev[b] = ($urandom_range(0, 39) == 0);
            we = ($urandom_range(0, 7) == 0);
            ul = ($urandom_range(0, 3) != 0);
            d  = $urandom;
            d[15:0] = d[15:0] & 16'h000F;
            if ($urandom_range(0, 1) == 0) d[25:24] = 2'b00;
            cyc(ev, we, ul, d);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule